// File: doc/BRIEF.md
# Non-Posted Request Tag Tracker

This block hands out transaction tags to the outgoing requests of one function and keeps a record of which tags are still waiting for an answer. A request that expects a completion takes a tag: memory read, I/O read, I/O write, config read or config write. The tag is the lowest-numbered one that is free in the active tag range. A posted request takes no tag and passes straight through the handshake: memory write, message, or message with data. When no tag is free, the block holds off further non-posted requests by lowering ready.

Completions come back in any order and carry only the tag to name the request they answer. The last completion for a request carries a final flag, and that completion frees its tag. A completion that names a tag with nothing outstanding raises a one-cycle error pulse and touches nothing else. The tag space can work in a standard 8-bit range (256 tags) or an extended 10-bit range (1024 tags). The range can be switched while the block runs, but a switch only takes effect at a moment when no tag is outstanding.

Top module: `tt_tag_tracker`

## Requirements
- R1: After synchronous reset the outstanding count is 0, full is low, the error pulse is low and the active range is standard (mode output 0).
- R2: A non-posted request is accepted on a cycle where valid and ready are both high. Non-posted means request type code 0 (memory read), 2 (I/O read), 3 (I/O write), 4 (config read) or 5 (config write). On acceptance the outstanding count rises by one in the next cycle, unless a tag also retires in that cycle.
- R3: Posted requests are always ready, take no tag and leave the count unchanged. Posted means request type code 1 (memory write), 6 (message) or 7 (message with data).
- R4: The tag presented with a non-posted request is the lowest-numbered tag that is free in the active range.
- R5: A tag that is outstanding is never handed out again until it has been retired.
- R6: A completion with the final flag set, naming an outstanding tag, retires that tag at the next clock edge. Tags may retire in any order.
- R7: A completion with the final flag clear retires nothing.
- R8: A completion naming a tag that is not outstanding makes the error output high for exactly the following cycle and changes no tag state and no count. This includes a tag outside the active range.
- R9: In standard mode only tags 0 to 255 are used. With 256 outstanding, full is high and ready is low for non-posted types, unless a tag retires in that same cycle.
- R10: In extended mode tags 0 to 1023 are used. Full is high with 1024 outstanding.
- R11: A retire and an allocation may happen in the same cycle. If the retiring tag is the lowest free one, that same tag is handed out again, so retire acts before allocate.
- R12: The requested mode input is taken as the active mode only in a cycle where the outstanding count is 0 and no tag is allocated. At all other times the mode output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext_i | input | 1 | Requested tag range: 1 extended, 0 standard |
| req_valid_i | input | 1 | Request present |
| req_type_i | input | 3 | Request type code |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_tag_o | output | TAG_W | Tag for the current non-posted request |
| cpl_valid_i | input | 1 | Completion present |
| cpl_tag_i | input | TAG_W | Tag carried by the completion |
| cpl_final_i | input | 1 | Last completion for its request |
| outstanding_o | output | TAG_W+1 | Number of tags in flight |
| full_o | output | 1 | Every tag of the active range is in flight |
| cpl_err_o | output | 1 | One-cycle pulse for a completion without a matching tag |
| mode_ext_o | output | 1 | Active tag range |

## Verification
The assertions assume the requester honours the handshake: a request only counts as accepted in a cycle where ready is high. They also assume completions arrive only for the tags the block presented, or as deliberately stray tags that must produce the error pulse. The stimulus drives every input half a cycle away from the active edge. It takes completion tags from a small low range, so that retires, stray completions and same-cycle retire/allocate collisions all occur often. It changes the requested mode both while tags are in flight and while none are, so that both the refused and the taken mode switch are exercised.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [2:0] {
        RK_MEM_RD  = 3'd0,
        RK_MEM_WR  = 3'd1,
        RK_IO_RD   = 3'd2,
        RK_IO_WR   = 3'd3,
        RK_CFG_RD  = 3'd4,
        RK_CFG_WR  = 3'd5,
        RK_MSG     = 3'd6,
        RK_MSG_DAT = 3'd7
    } req_kind_e;

    typedef struct packed {
        logic hit;     // completion names an outstanding tag
        logic retire;  // tag is freed this cycle
        logic stray;   // completion matches nothing
    } cpl_eval_s;

    function automatic logic needs_tag(input logic [2:0] code);
        req_kind_e k;
        k = req_kind_e'(code);
        case (k)
            RK_MEM_WR, RK_MSG, RK_MSG_DAT: needs_tag = 1'b0;
            default:                       needs_tag = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tt_lowest_free.sv
module tt_lowest_free #(
    parameter int N = 1024,
    parameter int W = 10
) (
    input  logic [N-1:0] avail,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/tt_tag_table.sv
module tt_tag_table #(
    parameter int TAG_W = 10,
    localparam int NTAGS = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ret_en,
    input  logic [TAG_W-1:0] ret_tag,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    output logic [NTAGS-1:0] busy
);
    // Retire is written first, allocate second: same-tag collision ends busy.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
        end else begin
            if (ret_en)   busy[ret_tag]   <= 1'b0;
            if (alloc_en) busy[alloc_tag] <= 1'b1;
        end
    end

    // R5: never hand out a tag that is still in flight (unless it retires now)
    p_no_reuse_r5: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> (!busy[alloc_tag] || (ret_en && ret_tag == alloc_tag)));

    // R6: only an in-flight tag may be retired
    p_retire_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ret_en |-> busy[ret_tag]);

    // R11: a tag freed and re-taken in one cycle stays in flight
    p_same_tag_r11: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && ret_en && ret_tag == alloc_tag) |=> busy[$past(alloc_tag)]);
endmodule

// File: rtl/tt_tag_tracker.sv
module tt_tag_tracker
    import tt_pkg::*;
#(
    parameter int TAG_W = 10,
    parameter int STD_W = 8,
    localparam int NTAGS = 1 << TAG_W,
    localparam int NSTD  = 1 << STD_W,
    localparam int CNT_W = TAG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_ext_i,
    input  logic             req_valid_i,
    input  logic [2:0]       req_type_i,
    output logic             req_ready_o,
    output logic [TAG_W-1:0] req_tag_o,
    input  logic             cpl_valid_i,
    input  logic [TAG_W-1:0] cpl_tag_i,
    input  logic             cpl_final_i,
    output logic [CNT_W-1:0] outstanding_o,
    output logic             full_o,
    output logic             cpl_err_o,
    output logic             mode_ext_o
);
    localparam logic [CNT_W-1:0] LIM_EXT = CNT_W'(NTAGS);
    localparam logic [CNT_W-1:0] LIM_STD = CNT_W'(NSTD);

    logic             mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic [NTAGS-1:0] busy;
    logic [NTAGS-1:0] in_rng;
    logic [NTAGS-1:0] avail;
    logic             tag_ok;
    logic             found;
    logic [TAG_W-1:0] pick;
    logic             np;
    logic             alloc_en;
    cpl_eval_s        ce;

    // Which tags belong to the active range
    for (genvar g = 0; g < NTAGS; g++) begin : g_rng
        if (g < NSTD) begin : g_std
            assign in_rng[g] = 1'b1;
        end else begin : g_ext
            assign in_rng[g] = mode_q;
        end
    end

    assign tag_ok = mode_q || ({1'b0, cpl_tag_i} < LIM_STD);

    always_comb begin
        ce.hit    = cpl_valid_i && tag_ok && busy[cpl_tag_i];
        ce.retire = ce.hit && cpl_final_i;
        ce.stray  = cpl_valid_i && !ce.hit;
    end

    // Retire acts before allocate: the freed tag is offered at once
    always_comb begin
        avail = ~busy & in_rng;
        if (ce.retire) avail[cpl_tag_i] = 1'b1;
    end

    tt_lowest_free #(.N(NTAGS), .W(TAG_W)) u_pick (
        .avail (avail),
        .found (found),
        .idx   (pick)
    );

    assign np          = needs_tag(req_type_i);
    assign req_ready_o = !np || found;
    assign req_tag_o   = pick;
    assign alloc_en    = req_valid_i && np && found;

    tt_tag_table #(.TAG_W(TAG_W)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .ret_en    (ce.retire),
        .ret_tag   (cpl_tag_i),
        .alloc_en  (alloc_en),
        .alloc_tag (pick),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            err_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(alloc_en) - CNT_W'(ce.retire);
            err_q <= ce.stray;
            if (cnt_q == '0 && !alloc_en) mode_q <= mode_ext_i;
        end
    end

    assign outstanding_o = cnt_q;
    assign full_o        = (cnt_q == (mode_q ? LIM_EXT : LIM_STD));
    assign cpl_err_o     = err_q;
    assign mode_ext_o    = mode_q;

    // R3: posted requests are never stalled
    p_posted_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !np) |-> req_ready_o);

    // R2: a lone allocation raises the count by one
    p_count_up_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && !ce.retire) |=> (outstanding_o == $past(outstanding_o) + 1'b1));

    // R9: full stalls non-posted traffic when nothing retires
    p_full_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (full_o && np && !ce.retire) |-> !req_ready_o);

    // R9 / R10: count never exceeds the active range
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        outstanding_o <= (mode_ext_o ? LIM_EXT : LIM_STD));

    // R8: a stray completion leaves the count alone when nothing is allocated
    p_stray_still_r8: assert property (@(posedge clk) disable iff (rst)
        (ce.stray && !alloc_en) |=> (cpl_err_o && $stable(outstanding_o)));

    // R12: mode cannot move while tags are in flight
    p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (outstanding_o != '0) |=> $stable(mode_ext_o));
endmodule

// File: tb/tt_tag_tracker_tb_top.sv
module tt_tag_tracker_tb_top;
    localparam int TAG_W = 10;
    localparam int CNT_W = TAG_W + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_ext_i = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [2:0]       req_type_i = 3'd0;
    logic             req_ready_o;
    logic [TAG_W-1:0] req_tag_o;
    logic             cpl_valid_i = 1'b0;
    logic [TAG_W-1:0] cpl_tag_i = '0;
    logic             cpl_final_i = 1'b0;
    logic [CNT_W-1:0] outstanding_o;
    logic             full_o;
    logic             cpl_err_o;
    logic             mode_ext_o;

    always #2 clk = ~clk;   // 250 MHz

    tt_tag_tracker dut_i (
        .clk           (clk),
        .rst           (rst),
        .mode_ext_i    (mode_ext_i),
        .req_valid_i   (req_valid_i),
        .req_type_i    (req_type_i),
        .req_ready_o   (req_ready_o),
        .req_tag_o     (req_tag_o),
        .cpl_valid_i   (cpl_valid_i),
        .cpl_tag_i     (cpl_tag_i),
        .cpl_final_i   (cpl_final_i),
        .outstanding_o (outstanding_o),
        .full_o        (full_o),
        .cpl_err_o     (cpl_err_o),
        .mode_ext_o    (mode_ext_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    bit m_out [1024];
    int m_cnt  = 0;
    bit m_mode = 1'b0;
    bit m_err  = 1'b0;
    int last_tag = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit is_np(input int t);
        return !(t == 1 || t == 6 || t == 7);
    endfunction

    // One cycle: drive at negedge, compare, update model at posedge
    task automatic step(input bit rv, input int rt, input bit cv, input int ct, input bit cf);
        int  lim;
        bit  hit, ret, fnd, alloc;
        int  etag;
        int  cnt0;
        req_valid_i = rv; req_type_i = 3'(rt);
        cpl_valid_i = cv; cpl_tag_i  = TAG_W'(ct); cpl_final_i = cf;
        #1;
        lim  = m_mode ? 1024 : 256;
        hit  = cv && ct < lim && m_out[ct];
        ret  = hit && cf;
        fnd  = 1'b0; etag = 0;
        for (int i = 0; i < lim; i++)
            if (!fnd && (!m_out[i] || (ret && ct == i))) begin fnd = 1'b1; etag = i; end
        alloc = rv && is_np(rt) && fnd;
        chk(is_np(rt) ? "R9" : "R3", "ready", int'(req_ready_o), int'(!is_np(rt) || fnd));
        if (alloc) begin
            chk("R4", "tag", int'(req_tag_o), etag);
            last_tag = int'(req_tag_o);
        end
        chk("R2", "count", int'(outstanding_o), m_cnt);
        chk(m_mode ? "R10" : "R9", "full", int'(full_o), int'(m_cnt == lim));
        chk("R8", "err", int'(cpl_err_o), int'(m_err));
        chk("R12", "mode", int'(mode_ext_o), int'(m_mode));
        @(posedge clk);
        cnt0  = m_cnt;
        m_err = cv && !hit;
        if (ret) begin m_out[ct] = 1'b0; m_cnt--; end
        if (alloc) begin m_out[etag] = 1'b1; m_cnt++; end
        if (cnt0 == 0 && !alloc) m_mode = mode_ext_i;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1", "count", int'(outstanding_o), 0);
        chk("R1", "full",  int'(full_o), 0);
        chk("R1", "err",   int'(cpl_err_o), 0);
        chk("R1", "mode",  int'(mode_ext_o), 0);

        // R2 / R4: each non-posted kind takes the next lowest tag
        step(1, 0, 0, 0, 0); step(1, 2, 0, 0, 0); step(1, 3, 0, 0, 0);
        step(1, 4, 0, 0, 0); step(1, 5, 0, 0, 0);
        // R3: posted kinds pass with no tag
        step(1, 1, 0, 0, 0); step(1, 6, 0, 0, 0); step(1, 7, 0, 0, 0);
        // R6: retire out of order (3 then 1); R4: next request reuses 1
        step(0, 0, 1, 3, 1); step(0, 0, 1, 1, 1); step(1, 0, 0, 0, 0);
        chk("R4", "reuse lowest", last_tag, 1);
        // R7: non-final completion keeps tag 2
        step(0, 0, 1, 2, 0); step(1, 4, 0, 0, 0);
        chk("R7", "tag after partial", last_tag, 3);
        // R8: stray completions, free tag and out-of-range tag in standard mode
        step(0, 0, 1, 200, 1); step(0, 0, 1, 300, 1); idle();
        // R11: retire tag 0 while requesting: tag 0 handed out again
        step(1, 0, 1, 0, 1);
        chk("R11", "same tag", last_tag, 0);
        // R11: retire 4 while lowest free is 5 elsewhere
        step(1, 2, 1, 4, 1);
        chk("R11", "mixed tag", last_tag, 4);
        // R12: mode request refused while tags are in flight
        mode_ext_i = 1'b1; idle(); idle();
        chk("R12", "mode held", int'(mode_ext_o), 0);
        mode_ext_i = 1'b0;
        // R9: fill standard range, then one more stalls
        while (m_cnt < 256) step(1, 0, 0, 0, 0);
        step(1, 3, 0, 0, 0); step(1, 1, 0, 0, 0);
        // R6: drain in descending order
        for (int i = 255; i >= 0; i--) step(0, 0, 1, i, 1);
        // R12: empty, switch to extended
        mode_ext_i = 1'b1; idle(); idle();
        chk("R12", "mode taken", int'(mode_ext_o), 1);
        // R10: fill 1024 tags
        while (m_cnt < 1024) step(1, 4, 0, 0, 0);
        step(1, 5, 0, 0, 0);
        chk("R10", "full ext", int'(full_o), 1);
        // R11: full, retire 777 and request together
        step(1, 0, 1, 777, 1);
        chk("R11", "refill 777", last_tag, 777);
        for (int i = 0; i < 1024; i++) step(0, 0, 1, i, 1);
        step(0, 0, 1, 900, 1);   // R8: stray in extended mode
        mode_ext_i = 1'b0; idle(); idle();
        // Mixed traffic
        for (int k = 0; k < 3000; k++) begin
            t = int'($urandom_range(7));
            if ($urandom_range(15) == 0) mode_ext_i = ~mode_ext_i;
            step(bit'($urandom_range(1)), t, bit'($urandom_range(1)),
                 int'($urandom_range(40)), bit'($urandom_range(3) != 0));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule